// File: doc/BRIEF.md
# Context-Tagged Virtual Cache with Alias Rescue

This block is a direct-mapped, virtually indexed, write-through data cache. Each line carries a valid bit, a context number, the virtual tag and the full physical word address. A request supplies its virtual address, the current context number and the physical address that the translation unit outside the block produced for it. A lookup hits only when the line is valid and both the virtual tag and the context number match.

When the virtual tag or the context does not match, the block compares the physical address of the request with the physical address held in the indexed line. If they are equal, the same data is resident under another context or another virtual name. The block then serves it from the line one cycle later than a normal hit and rewrites the line's context and virtual tag, so later accesses under the new name hit at full speed. If the addresses differ, the request goes to memory as an ordinary miss. Reads that miss fill the line. Writes always go to memory; a write whose line is resident by hit or alias also updates the line.

Context numbers are handed out cyclically. When the allocator wraps, a pulse on `ctx_wrap` starts a sweep that invalidates one line per cycle. The sweep covers the whole array. No request is taken while it runs.

Top module: `ctx_tag_vcache`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` and `mem_req` are 0, and every line is invalid, so the first access to any index goes to memory.
- R2: A read accepted while the indexed line is valid and both its virtual tag (`req_va` above the low `IDX_W` bits) and its context equal the request's is answered with `rsp_valid` in the cycle after acceptance, with the line's data and no memory request.
- R3: A line holding the requested virtual tag under a different context, with a different physical address, does not hit: the read goes to memory.
- R4: A read that misses on virtual tag or context, but whose `req_pa` equals the physical address of the valid indexed line, is answered two cycles after acceptance with the line's data and no memory request.
- R5: After the case in R4, the line carries the new context and virtual tag. A repeat of that access hits in one cycle, and an access under the line's previous name no longer hits.
- R6: A read miss raises `mem_req` with `mem_write` 0 and `mem_addr` equal to `req_pa`. The cycle after `mem_ack` brings `rsp_valid` with `mem_rdata`, and the line is filled under the request's context, virtual tag and physical address.
- R7: Every write issues one memory write of `req_wdata` to `req_pa`. A write that hits or aliases also updates and retags the line, so a later read hits and returns the new data. A write that misses leaves the line unchanged, so a later read of that address goes to memory.
- R8: When `ctx_wrap` is sampled high, `req_ready` is low in that cycle and in the following `2**IDX_W` cycles while all lines are invalidated. Afterwards every access goes to memory.
- R9: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_addr`, `mem_write` and `mem_wdata` hold their values into the next cycle.
- R10: `req_ready` is low while a request is in progress. Each accepted request produces exactly one `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ctx | input | CTX_W | Current context number |
| req_va | input | VA_W | Virtual word address; low IDX_W bits are the index |
| req_pa | input | PA_W | Translated physical word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DATA_W | Read data (0 for writes) |
| ctx_wrap | input | 1 | Context allocator wrapped; start the invalidate sweep |
| mem_req | output | 1 | Memory access pending |
| mem_write | output | 1 | Memory access is a write |
| mem_addr | output | PA_W | Memory physical word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory completes the pending access |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |

## Verification
A corrupted tag or context field shows at the ports on the next access to that index. It appears either as a memory request where none was due or as a response one cycle early or late. The latency of every access is measured and checked against a reference model of the tag array, so a wrong classification is caught on the very access that makes it. A stale data word after a retag or a write-hit shows up as wrong read data on the following hit. A sweep that skips a line shows up as a missing memory request on the first access after the wrap.

// File: rtl/ctv_pkg.sv
package ctv_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ALIAS = 2'd1,
      ST_MEM   = 2'd2,
      ST_SWEEP = 2'd3
   } ctv_state_e;
endpackage

// File: rtl/ctv_line_store.sv
module ctv_line_store #(
   parameter int IDX_W  = 4,
   parameter int CTX_W  = 8,
   parameter int VTAG_W = 12,
   parameter int PA_W   = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic [CTX_W-1:0]  rd_ctx,
   output logic [VTAG_W-1:0] rd_vtag,
   output logic [PA_W-1:0]   rd_pa,
   output logic [DATA_W-1:0] rd_data,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              tag_we,
   input  logic [CTX_W-1:0]  tag_ctx,
   input  logic [VTAG_W-1:0] tag_vtag,
   input  logic [PA_W-1:0]   tag_pa,
   input  logic              data_we,
   input  logic [DATA_W-1:0] data_in,
   input  logic              inv_en,
   input  logic [IDX_W-1:0]  inv_idx
);
   localparam int LINES = 1 << IDX_W;

   logic [LINES-1:0]  valid_q;
   logic [CTX_W-1:0]  ctx_q  [LINES];
   logic [VTAG_W-1:0] vtag_q [LINES];
   logic [PA_W-1:0]   pa_q   [LINES];
   logic [DATA_W-1:0] data_q [LINES];

   // valid bits: reset, sweep clear, set on tag write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (inv_en) begin
         valid_q[inv_idx] <= 1'b0;
      end else if (tag_we) begin
         valid_q[wr_idx] <= 1'b1;
      end
   end

   // tag and data fields need no reset: guarded by valid
   always_ff @(posedge clk) begin
      if (tag_we) begin
         ctx_q[wr_idx]  <= tag_ctx;
         vtag_q[wr_idx] <= tag_vtag;
         pa_q[wr_idx]   <= tag_pa;
      end
      if (data_we) begin
         data_q[wr_idx] <= data_in;
      end
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_ctx   = ctx_q[rd_idx];
   assign rd_vtag  = vtag_q[rd_idx];
   assign rd_pa    = pa_q[rd_idx];
   assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/ctv_tag_match.sv
module ctv_tag_match #(
   parameter int CTX_W        = 8,
   parameter int VTAG_W       = 12,
   parameter int PA_W         = 16,
   parameter bit ALIAS_RESCUE = 1'b1
) (
   input  logic              line_valid,
   input  logic [CTX_W-1:0]  line_ctx,
   input  logic [VTAG_W-1:0] line_vtag,
   input  logic [PA_W-1:0]   line_pa,
   input  logic [CTX_W-1:0]  want_ctx,
   input  logic [VTAG_W-1:0] want_vtag,
   input  logic [PA_W-1:0]   want_pa,
   output logic              hit,
   output logic              alias_hit
);
   logic name_eq;
   assign name_eq = (line_ctx == want_ctx) && (line_vtag == want_vtag);
   assign hit     = line_valid && name_eq;

   generate
      if (ALIAS_RESCUE) begin : g_rescue
         assign alias_hit = line_valid && !name_eq && (line_pa == want_pa);
      end else begin : g_plain
         logic unused_pa;
         assign unused_pa = ^{line_pa, want_pa};
         assign alias_hit = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/ctv_sweep.sv
module ctv_sweep #(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   output logic [IDX_W-1:0] idx,
   output logic             last
);
   localparam logic [IDX_W-1:0] TOP = {IDX_W{1'b1}};

   logic [IDX_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (run) begin
         cnt_q <= (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
      end
   end

   assign idx  = cnt_q;
   assign last = run && (cnt_q == TOP);
endmodule

// File: rtl/ctx_tag_vcache.sv
module ctx_tag_vcache
   import ctv_pkg::*;
#(
   parameter int VA_W         = 16,
   parameter int PA_W         = 16,
   parameter int IDX_W        = 4,
   parameter int CTX_W        = 8,
   parameter int DATA_W       = 32,
   parameter bit ALIAS_RESCUE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [CTX_W-1:0]  req_ctx,
   input  logic [VA_W-1:0]   req_va,
   input  logic [PA_W-1:0]   req_pa,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   input  logic              ctx_wrap,
   output logic              mem_req,
   output logic              mem_write,
   output logic [PA_W-1:0]   mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int VTAG_W = VA_W - IDX_W;

   generate
      if (VA_W <= IDX_W) begin : g_bad_va
         $error("VA_W must exceed IDX_W");
      end
      if (PA_W < IDX_W) begin : g_bad_pa
         $error("PA_W must be at least IDX_W");
      end
      if (CTX_W < 1 || DATA_W < 1) begin : g_bad_w
         $error("CTX_W and DATA_W must be positive");
      end
   endgenerate

   ctv_state_e state_q;

   logic [IDX_W-1:0]  r_idx;
   logic [CTX_W-1:0]  r_ctx;
   logic [VTAG_W-1:0] r_vtag;
   logic [PA_W-1:0]   r_pa;
   logic [DATA_W-1:0] r_wdata;
   logic              r_write;
   logic              wrap_pend_q;
   logic              rsp_valid_q;
   logic [DATA_W-1:0] rsp_rdata_q;

   logic [IDX_W-1:0]  req_idx;
   logic [VTAG_W-1:0] req_vtag;
   logic              accept;

   assign req_idx   = req_va[IDX_W-1:0];
   assign req_vtag  = req_va[VA_W-1:IDX_W];
   assign req_ready = (state_q == ST_IDLE) && !ctx_wrap && !wrap_pend_q;
   assign accept    = req_valid && req_ready;

   // ---------------- line store ----------------
   logic [IDX_W-1:0]  rd_idx;
   logic              ln_valid;
   logic [CTX_W-1:0]  ln_ctx;
   logic [VTAG_W-1:0] ln_vtag;
   logic [PA_W-1:0]   ln_pa;
   logic [DATA_W-1:0] ln_data;

   logic [IDX_W-1:0]  wr_idx;
   logic              tag_we;
   logic [CTX_W-1:0]  tag_ctx;
   logic [VTAG_W-1:0] tag_vtag;
   logic [PA_W-1:0]   tag_pa;
   logic              data_we;
   logic [DATA_W-1:0] data_in;
   logic              inv_en;
   logic [IDX_W-1:0]  inv_idx;
   logic              sw_last;

   assign rd_idx = (state_q == ST_IDLE) ? req_idx : r_idx;

   ctv_line_store #(
      .IDX_W (IDX_W),
      .CTX_W (CTX_W),
      .VTAG_W(VTAG_W),
      .PA_W  (PA_W),
      .DATA_W(DATA_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (rd_idx),
      .rd_valid(ln_valid),
      .rd_ctx  (ln_ctx),
      .rd_vtag (ln_vtag),
      .rd_pa   (ln_pa),
      .rd_data (ln_data),
      .wr_idx  (wr_idx),
      .tag_we  (tag_we),
      .tag_ctx (tag_ctx),
      .tag_vtag(tag_vtag),
      .tag_pa  (tag_pa),
      .data_we (data_we),
      .data_in (data_in),
      .inv_en  (inv_en),
      .inv_idx (inv_idx)
   );

   // ---------------- tag compare ----------------
   logic lk_hit;
   logic lk_alias;

   ctv_tag_match #(
      .CTX_W       (CTX_W),
      .VTAG_W      (VTAG_W),
      .PA_W        (PA_W),
      .ALIAS_RESCUE(ALIAS_RESCUE)
   ) u_match (
      .line_valid(ln_valid),
      .line_ctx  (ln_ctx),
      .line_vtag (ln_vtag),
      .line_pa   (ln_pa),
      .want_ctx  (req_ctx),
      .want_vtag (req_vtag),
      .want_pa   (req_pa),
      .hit       (lk_hit),
      .alias_hit (lk_alias)
   );

   // ---------------- invalidate sweep ----------------
   ctv_sweep #(
      .IDX_W(IDX_W)
   ) u_sweep (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (state_q == ST_SWEEP),
      .idx  (inv_idx),
      .last (sw_last)
   );

   assign inv_en = (state_q == ST_SWEEP);

   // ---------------- store write control ----------------
   always_comb begin
      wr_idx   = r_idx;
      tag_we   = 1'b0;
      tag_ctx  = r_ctx;
      tag_vtag = r_vtag;
      tag_pa   = r_pa;
      data_we  = 1'b0;
      data_in  = mem_rdata;
      unique case (state_q)
         ST_IDLE: begin
            if (accept && req_write && (lk_hit || lk_alias)) begin
               wr_idx   = req_idx;
               tag_we   = 1'b1;
               tag_ctx  = req_ctx;
               tag_vtag = req_vtag;
               tag_pa   = req_pa;
               data_we  = 1'b1;
               data_in  = req_wdata;
            end
         end
         ST_ALIAS: begin
            tag_we = 1'b1;
         end
         ST_MEM: begin
            if (mem_ack && !r_write) begin
               tag_we  = 1'b1;
               data_we = 1'b1;
            end
         end
         default: begin
         end
      endcase
   end

   // ---------------- control ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         r_idx       <= '0;
         r_ctx       <= '0;
         r_vtag      <= '0;
         r_pa        <= '0;
         r_wdata     <= '0;
         r_write     <= 1'b0;
         wrap_pend_q <= 1'b0;
         rsp_valid_q <= 1'b0;
         rsp_rdata_q <= '0;
      end else begin
         rsp_valid_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (ctx_wrap || wrap_pend_q) begin
                  state_q     <= ST_SWEEP;
                  wrap_pend_q <= 1'b0;
               end else if (accept) begin
                  r_idx   <= req_idx;
                  r_ctx   <= req_ctx;
                  r_vtag  <= req_vtag;
                  r_pa    <= req_pa;
                  r_wdata <= req_wdata;
                  r_write <= req_write;
                  if (req_write) begin
                     state_q <= ST_MEM;
                  end else if (lk_hit) begin
                     rsp_valid_q <= 1'b1;
                     rsp_rdata_q <= ln_data;
                  end else if (lk_alias) begin
                     state_q <= ST_ALIAS;
                  end else begin
                     state_q <= ST_MEM;
                  end
               end
            end
            ST_ALIAS: begin
               rsp_valid_q <= 1'b1;
               rsp_rdata_q <= ln_data;
               state_q     <= ST_IDLE;
            end
            ST_MEM: begin
               if (mem_ack) begin
                  rsp_valid_q <= 1'b1;
                  rsp_rdata_q <= r_write ? '0 : mem_rdata;
                  state_q     <= ST_IDLE;
               end
            end
            ST_SWEEP: begin
               if (sw_last) begin
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
         if (ctx_wrap && state_q != ST_IDLE) begin
            wrap_pend_q <= 1'b1;
         end
      end
   end

   assign rsp_valid = rsp_valid_q;
   assign rsp_rdata = rsp_rdata_q;
   assign mem_req   = (state_q == ST_MEM);
   assign mem_write = r_write;
   assign mem_addr  = r_pa;
   assign mem_wdata = r_wdata;
endmodule

// File: rtl/ctv_checker.sv
module ctv_checker #(
   parameter int PA_W   = 16,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_write,
   input logic              lk_hit,
   input logic              lk_alias,
   input logic              rsp_valid,
   input logic              ctx_wrap,
   input logic              mem_req,
   input logic              mem_write,
   input logic [PA_W-1:0]   mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_ack
);
   logic acc;
   assign acc = req_valid && req_ready;

   AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !req_write && lk_hit |=> rsp_valid && !mem_req);  // R2

   AST_ALIAS_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !req_write && lk_alias |=> !rsp_valid ##1 (rsp_valid && !mem_req));  // R4

   AST_MISS_GOES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !lk_hit && !lk_alias |=> mem_req);  // R6

   AST_RSP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ack |=> rsp_valid);  // R6

   AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      acc && req_write |=> mem_req && mem_write);  // R7

   AST_WRAP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_wrap |=> !req_ready);  // R8

   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata));  // R9

   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !req_ready);  // R10
endmodule

bind ctx_tag_vcache ctv_checker #(
   .PA_W  (PA_W),
   .DATA_W(DATA_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_ready(req_ready),
   .req_write(req_write),
   .lk_hit   (lk_hit),
   .lk_alias (lk_alias),
   .rsp_valid(rsp_valid),
   .ctx_wrap (ctx_wrap),
   .mem_req  (mem_req),
   .mem_write(mem_write),
   .mem_addr (mem_addr),
   .mem_wdata(mem_wdata),
   .mem_ack  (mem_ack)
);

// File: tb/sim_ctx_tag_vcache.sv
`timescale 1ns/1ps
module sim_ctx_tag_vcache;
   localparam int VA_W = 16, PA_W = 16, IDX_W = 4, CTX_W = 8, DATA_W = 32;
   localparam int LINES = 1 << IDX_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic              req_write = 1'b0;
   logic [CTX_W-1:0]  req_ctx = '0;
   logic [VA_W-1:0]   req_va = '0;
   logic [PA_W-1:0]   req_pa = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic              rsp_valid;
   logic [DATA_W-1:0] rsp_rdata;
   logic              ctx_wrap = 1'b0;
   logic              mem_req;
   logic              mem_write;
   logic [PA_W-1:0]   mem_addr;
   logic [DATA_W-1:0] mem_wdata;
   logic              mem_ack = 1'b0;
   logic [DATA_W-1:0] mem_rdata = '0;

   always #4 clk = ~clk;

   ctx_tag_vcache u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_ctx(req_ctx), .req_va(req_va), .req_pa(req_pa), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ctx_wrap(ctx_wrap),
      .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   // ---------------- memory model ----------------
   bit [31:0] mstore [bit [15:0]];
   int        txn_cnt = 0;
   logic [15:0] last_addr = '0;
   logic        last_wr = 1'b0;
   logic [31:0] last_wdata = '0;
   int          wait_cnt = 1;

   function automatic logic [31:0] memval(input logic [15:0] pa);
      if (mstore.exists(pa)) return mstore[pa];
      return {pa, ~pa} ^ 32'h1357_9BDF;
   endfunction

   initial begin
      forever begin
         @(negedge clk);
         if (mem_ack) begin
            mem_ack = 1'b0;
         end else if (mem_req) begin
            if (wait_cnt == 0) begin
               mem_ack    = 1'b1;
               mem_rdata  = memval(mem_addr);
               last_addr  = mem_addr;
               last_wr    = mem_write;
               last_wdata = mem_wdata;
               if (mem_write) mstore[mem_addr] = mem_wdata;
               txn_cnt++;
               wait_cnt = int'($urandom % 3);
            end else begin
               wait_cnt--;
            end
         end
      end
   end

   // ---------------- reference tag array ----------------
   bit          m_v    [LINES];
   logic [7:0]  m_ctx  [LINES];
   logic [11:0] m_vtag [LINES];
   logic [15:0] m_pa   [LINES];

   function automatic logic [15:0] mk_va(input int vt, input int idx);
      return {12'h100 | 12'(vt), 4'(idx)};
   endfunction
   function automatic logic [15:0] mk_pa(input int ctx, input int vt, input int idx);
      return {12'hA00 | 12'((vt + ctx) & 3), 4'(idx)};
   endfunction
   // 0 hit, 1 alias, 2 miss
   function automatic int classify(input int ctx, input int vt, input int idx);
      logic [15:0] pa;
      pa = mk_pa(ctx, vt, idx);
      if (m_v[idx] && m_ctx[idx] == 8'(ctx) && m_vtag[idx] == (12'h100 | 12'(vt))) return 0;
      if (m_v[idx] && m_pa[idx] == pa) return 1;
      return 2;
   endfunction

   // ---------------- one access ----------------
   task automatic access(input bit wr, input int ctx, input int vt, input int idx,
                         input logic [31:0] wd, input string tag);
      int          cls, lat, t0;
      bit          stable_ok;
      logic [15:0] pa;
      logic [31:0] exp_d, got;
      pa    = mk_pa(ctx, vt, idx);
      cls   = classify(ctx, vt, idx);
      exp_d = memval(pa);
      @(negedge clk);
      req_write = wr; req_ctx = 8'(ctx); req_va = mk_va(vt, idx);
      req_pa = pa; req_wdata = wd; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      t0 = txn_cnt;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      stable_ok = 1'b1;
      while (!rsp_valid && lat < 60) begin
         if (mem_req && (mem_addr != pa || mem_write != wr || (wr && mem_wdata != wd)))
            stable_ok = 1'b0;
         @(negedge clk);
         lat++;
      end
      got = rsp_rdata;
      chk(rsp_valid, "R10", {tag, " response arrives"}, 32'(lat), 32'd0);
      chk(stable_ok, "R9", {tag, " memory request held"}, 32'(stable_ok), 32'd1);
      if (wr) begin
         chk(txn_cnt - t0 == 1 && last_wr && last_addr == pa && last_wdata == wd,
             "R7", {tag, " write goes through"}, {16'(txn_cnt - t0), last_addr}, {16'd1, pa});
         if (cls != 2) begin
            m_ctx[idx] = 8'(ctx); m_vtag[idx] = 12'h100 | 12'(vt);
         end
      end else if (cls == 0) begin
         chk(lat == 1 && txn_cnt == t0, "R2", {tag, " hit latency"}, 32'(lat), 32'd1);
         chk(got == exp_d, "R2", {tag, " hit data"}, got, exp_d);
      end else if (cls == 1) begin
         chk(lat == 2 && txn_cnt == t0, "R4", {tag, " alias latency"}, 32'(lat), 32'd2);
         chk(got == exp_d, "R4", {tag, " alias data"}, got, exp_d);
         m_ctx[idx] = 8'(ctx); m_vtag[idx] = 12'h100 | 12'(vt);
      end else begin
         chk(txn_cnt - t0 == 1 && !last_wr && last_addr == pa, "R6", {tag, " miss fetch"},
             {16'(txn_cnt - t0), last_addr}, {16'd1, pa});
         chk(got == exp_d, "R6", {tag, " miss data"}, got, exp_d);
         m_v[idx] = 1'b1; m_ctx[idx] = 8'(ctx);
         m_vtag[idx] = 12'h100 | 12'(vt); m_pa[idx] = pa;
      end
      @(negedge clk);
      chk(!rsp_valid, "R10", {tag, " single response"}, 32'(rsp_valid), 32'd0);
   endtask

   task automatic expect_class(input int ctx, input int vt, input int idx,
                               input int want, input string rq);
      chk(classify(ctx, vt, idx) == want, rq, "model class", 32'(classify(ctx, vt, idx)), 32'(want));
   endtask

   task automatic do_wrap();
      int cnt;
      @(negedge clk);
      ctx_wrap = 1'b1;
      @(negedge clk);
      ctx_wrap = 1'b0;
      cnt = 0;
      while (!req_ready && cnt < 100) begin
         cnt++;
         @(negedge clk);
      end
      chk(cnt == LINES, "R8", "sweep busy cycles", 32'(cnt), 32'(LINES));
      for (int i = 0; i < LINES; i++) m_v[i] = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int s;
      s = int'($urandom(32'd4242));
      for (int i = 0; i < LINES; i++) m_v[i] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !rsp_valid && !mem_req, "R1", "reset outputs",
          {29'd0, req_ready, rsp_valid, mem_req}, 32'h4);

      // R1, R6: first access misses
      access(1'b0, 1, 0, 5, '0, "R1 cold");
      // R2: repeat hits
      access(1'b0, 1, 0, 5, '0, "R2 repeat");
      // R3: same virtual tag, other context, other PA
      expect_class(2, 0, 5, 2, "R3");
      access(1'b0, 2, 0, 5, '0, "R3 ctx differs");
      // R4: ctx1/vt1 maps to same PA as ctx2/vt0
      expect_class(1, 1, 5, 1, "R4");
      access(1'b0, 1, 1, 5, '0, "R4 alias");
      // R5: retagged line hits, old name aliases again
      expect_class(1, 1, 5, 0, "R5");
      access(1'b0, 1, 1, 5, '0, "R5 after retag");
      expect_class(2, 0, 5, 1, "R5");
      access(1'b0, 2, 0, 5, '0, "R5 old name");
      // R7: write hit updates the line
      access(1'b1, 2, 0, 5, 32'hCAFE_0001, "R7 write hit");
      expect_class(2, 0, 5, 0, "R7");
      access(1'b0, 2, 0, 5, '0, "R7 read after write");
      // R7: write miss allocates nothing
      access(1'b1, 1, 0, 9, 32'hBEEF_0002, "R7 write miss");
      expect_class(1, 0, 9, 2, "R7");
      access(1'b0, 1, 0, 9, '0, "R7 read after write miss");
      // R8: wrap invalidates everything
      do_wrap();
      expect_class(2, 0, 5, 2, "R8");
      access(1'b0, 2, 0, 5, '0, "R8 after wrap");

      for (int n = 0; n < 400; n++) begin
         bit wr;
         wr = ($urandom % 4) == 0;
         access(wr, 1 + int'($urandom % 3), int'($urandom % 4), int'($urandom % 4),
                $urandom, "random");
         if (n % 130 == 129) do_wrap();
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule